// File: doc/BRIEF.md
# Power-of-Two Region Access Guard

This block decides, for every instruction fetch and every load or store, whether the access may proceed or must be turned into an access fault. It keeps a small table of protection regions. Each region is an aligned block of memory whose size is a power of two, described by one address register and one configuration byte. The configuration byte carries read, write and execute permissions, a match-mode field and a lock bit. The surrounding CPU decodes its own control-register instructions and presents the resulting writes on a simple write port. It also takes the fault outputs and performs trap entry itself.

The region size is encoded by the run of ones at the bottom of the address register. A write to an address register starts a counter that walks this run one bit per cycle. While the walk is in progress, the region is marked not ready and matches nothing. When the walk ends, the compare mask is fixed and the region takes part in checking again. When regions overlap, the lowest-numbered matching region alone decides the outcome. Accesses in user mode are always checked. Accesses in machine mode are checked only against regions that have their lock bit set.

Top module: `napot_guard`

## Requirements
- R1: After reset every region is switched off, and no access of any kind and in either privilege mode raises a fault.
- R2: A configuration write (`csr_we`=1, `csr_is_addr`=0) stores `csr_wdata[7:0]` into region `csr_idx`, and it takes effect from the next clock edge. The byte layout is bit 0 read, bit 1 write, bit 2 execute, bits 4:3 match mode and bit 7 lock. Mode value 3 selects power-of-two matching. Values 0, 1 and 2 all mean the region is off.
- R3: An address write (`csr_is_addr`=1) stores `csr_wdata[ADDR_W-3:0]` as byte-address bits [ADDR_W-1:2]. If the register has k trailing ones, the region covers 2^(k+3) bytes aligned to that size. With all bits set, it covers the whole space. The size is never smaller than 2^MIN_GRAN_LOG2 bytes.
- R4: After an address write, the region matches nothing until its size walk completes. This happens at the (k+1)-th clock edge after the write, and never later than ADDR_W-1 edges after it.
- R5: A load that falls in the deciding region raises `ld_fault` when that region's read bit is clear.
- R6: A store that falls in the deciding region raises `st_fault` when that region's write bit is clear.
- R7: A fetch that falls in the deciding region raises `if_fault` when that region's execute bit is clear.
- R8: In machine mode (`priv_user`=0), the deciding region applies its permissions only if its lock bit is set. Otherwise the access is allowed.
- R9: When several regions match an address, only the lowest-numbered one decides.
- R10: An access that matches no region is allowed.
- R11: Fault outputs stay low while the corresponding request is low, and `ld_fault` and `st_fault` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_is_addr | input | 1 | 1 selects the address register, 0 the configuration byte |
| csr_idx | input | IDX_W | Region number written |
| csr_wdata | input | DATA_W | Write data |
| priv_user | input | 1 | 1 when the access comes from user mode |
| if_req | input | 1 | Fetch request |
| if_addr | input | ADDR_W | Fetch byte address |
| if_fault | output | 1 | Instruction access fault |
| ls_req | input | 1 | Load/store request |
| ls_we | input | 1 | 1 for store, 0 for load |
| ls_addr | input | ADDR_W | Load/store byte address |
| ld_fault | output | 1 | Load access fault |
| st_fault | output | 1 | Store access fault |

## Verification
The assertions assume that a new address write to a region may arrive at any time, including during an ongoing size walk. The write simply restarts the walk, so the bound on settling time is measured from the latest write. They also assume that the request and privilege inputs are stable around the sampling edge, since the faults are combinational in those inputs. The stimulus changes inputs only on the falling edge. It probes permissions only after waiting well past the longest walk, except for the deliberate probe made inside the settling window.

// File: rtl/napot_guard_pkg.sv
package napot_guard_pkg;

  localparam logic [1:0] MODE_POW2 = 2'b11;

  typedef struct packed {
    logic       lock;
    logic [1:0] mode;
    logic       x;
    logic       w;
    logic       r;
  } rgn_cfg_t;

  function automatic rgn_cfg_t unpack_cfg(input logic [7:0] b);
    rgn_cfg_t c;
    c.lock = b[7];
    c.mode = b[4:3];
    c.x    = b[2];
    c.w    = b[1];
    c.r    = b[0];
    return c;
  endfunction

endpackage

// File: rtl/npc_region_scan.sv
module npc_region_scan #(
  parameter int ARW  = 30,
  parameter int AW   = 32,
  parameter int GRAN = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_en,
  input  logic [ARW-1:0] load_val,
  output logic [AW-1:0]  base_o,
  output logic [AW-1:0]  care_o,
  output logic           valid_o
);

  localparam int CNT_W = $clog2(ARW + 1);

  logic [ARW-1:0]   addr_q, addr_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             busy_q, busy_d;
  logic             valid_q, valid_d;
  logic [AW-1:0]    care_q, care_d;
  logic             cur_one;
  logic             upd_en;

  function automatic logic [AW-1:0] care_of(input logic [CNT_W-1:0] ones);
    logic [AW-1:0] m;
    int lim;
    lim = int'(ones) + 3;
    if (lim < GRAN) lim = GRAN;
    for (int b = 0; b < AW; b++) m[b] = (b >= lim);
    return m;
  endfunction

  // next state: walk the trailing-ones run one bit per cycle
  always_comb begin
    addr_d  = addr_q;
    idx_d   = idx_q;
    busy_d  = busy_q;
    valid_d = valid_q;
    care_d  = care_q;
    cur_one = 1'b0;
    for (int i = 0; i < ARW; i++) begin
      if (idx_q == i[CNT_W-1:0]) cur_one = addr_q[i];
    end
    if (load_en) begin
      addr_d  = load_val;
      idx_d   = '0;
      busy_d  = 1'b1;
      valid_d = 1'b0;
    end else if (busy_q) begin
      if (cur_one) begin
        idx_d = idx_q + 1'b1;
      end else begin
        busy_d  = 1'b0;
        valid_d = 1'b1;
        care_d  = care_of(idx_q);
      end
    end
  end

  assign upd_en = load_en | busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      care_q  <= '0;
    end else if (upd_en) begin
      addr_q  <= addr_d;
      idx_q   <= idx_d;
      busy_q  <= busy_d;
      valid_q <= valid_d;
      care_q  <= care_d;
    end
  end

  assign base_o  = {addr_q, 2'b00};
  assign care_o  = care_q;
  assign valid_o = valid_q;

  // cycles spent walking since the latest address write
  logic [CNT_W:0] walk_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        walk_cnt_q <= '0;
    else if (load_en)  walk_cnt_q <= '0;
    else if (busy_q)   walk_cnt_q <= walk_cnt_q + 1'b1;
    else               walk_cnt_q <= '0;
  end

  AST_LOAD_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (!valid_o && busy_q)); // R4
  AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(walk_cnt_q) <= ARW + 1); // R4

endmodule

// File: rtl/npc_match.sv
module npc_match #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] care,
  input  logic          ready,
  input  logic          enabled,
  output logic          hit
);

  assign hit = ready & enabled & (((addr ^ base) & care) == '0);

endmodule

// File: rtl/npc_decide.sv
module npc_decide #(
  parameter int N = 4
) (
  input  logic         req,
  input  logic         priv_user,
  input  logic [N-1:0] hit,
  input  logic [N-1:0] perm,
  input  logic [N-1:0] lock,
  output logic         fault
);

  logic found;
  logic deny;

  // lowest-numbered matching region decides
  always_comb begin
    found = 1'b0;
    deny  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!found && hit[i]) begin
        found = 1'b1;
        if (priv_user || lock[i]) deny = !perm[i];
      end
    end
  end

  assign fault = req & deny;

endmodule

// File: rtl/napot_guard.sv
module napot_guard
  import napot_guard_pkg::*;
#(
  parameter int NUM_REGIONS   = 4,
  parameter int ADDR_W        = 32,
  parameter int DATA_W        = 32,
  parameter int MIN_GRAN_LOG2 = 3,
  parameter int IDX_W         = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic              csr_is_addr,
  input  logic [IDX_W-1:0]  csr_idx,
  input  logic [DATA_W-1:0] csr_wdata,
  input  logic              priv_user,
  input  logic              if_req,
  input  logic [ADDR_W-1:0] if_addr,
  output logic              if_fault,
  input  logic              ls_req,
  input  logic              ls_we,
  input  logic [ADDR_W-1:0] ls_addr,
  output logic              ld_fault,
  output logic              st_fault
);

  localparam int ARW = ADDR_W - 2;

  if (NUM_REGIONS == 0) begin : g_none
    assign if_fault = 1'b0;
    assign ld_fault = 1'b0;
    assign st_fault = 1'b0;
    logic unused_in;
    assign unused_in = ^{clk, rst_n, csr_we, csr_is_addr, csr_idx, csr_wdata,
                         priv_user, if_req, if_addr, ls_req, ls_we, ls_addr};
  end else begin : g_prot

    // reset: asynchronous assert, synchronous release
    logic rst_meta_q, rst_ni;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rst_meta_q <= 1'b0;
        rst_ni     <= 1'b0;
      end else begin
        rst_meta_q <= 1'b1;
        rst_ni     <= rst_meta_q;
      end
    end

    rgn_cfg_t cfg_q [NUM_REGIONS];
    rgn_cfg_t cfg_d [NUM_REGIONS];
    logic     cfg_en;

    always_comb begin
      for (int i = 0; i < NUM_REGIONS; i++) begin
        cfg_d[i] = cfg_q[i];
        if (csr_we && !csr_is_addr && (csr_idx == i[IDX_W-1:0]))
          cfg_d[i] = unpack_cfg(csr_wdata[7:0]);
      end
    end

    assign cfg_en = csr_we & ~csr_is_addr;

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < NUM_REGIONS; i++) cfg_q[i] <= '0;
      end else if (cfg_en) begin
        for (int i = 0; i < NUM_REGIONS; i++) cfg_q[i] <= cfg_d[i];
      end
    end

    logic unused_wdata;
    assign unused_wdata = ^{csr_wdata[DATA_W-1:8], csr_wdata[6:5]};

    logic [NUM_REGIONS-1:0] if_hit, ls_hit;
    logic [NUM_REGIONS-1:0] x_vec, w_vec, r_vec, lock_vec;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
      logic              load_en;
      logic [ADDR_W-1:0] base, care;
      logic              ready, pow2_on;

      assign load_en = csr_we & csr_is_addr & (csr_idx == MY_IDX);
      assign pow2_on = (cfg_q[g].mode == MODE_POW2);

      npc_region_scan #(.ARW(ARW), .AW(ADDR_W), .GRAN(MIN_GRAN_LOG2)) u_scan (
        .clk      (clk),
        .rst_n    (rst_ni),
        .load_en  (load_en),
        .load_val (csr_wdata[ARW-1:0]),
        .base_o   (base),
        .care_o   (care),
        .valid_o  (ready)
      );

      npc_match #(.AW(ADDR_W)) u_if_match (
        .addr(if_addr), .base(base), .care(care),
        .ready(ready), .enabled(pow2_on), .hit(if_hit[g])
      );

      npc_match #(.AW(ADDR_W)) u_ls_match (
        .addr(ls_addr), .base(base), .care(care),
        .ready(ready), .enabled(pow2_on), .hit(ls_hit[g])
      );

      assign x_vec[g]    = cfg_q[g].x;
      assign w_vec[g]    = cfg_q[g].w;
      assign r_vec[g]    = cfg_q[g].r;
      assign lock_vec[g] = cfg_q[g].lock;
    end

    logic ls_deny;

    npc_decide #(.N(NUM_REGIONS)) u_if_decide (
      .req(if_req), .priv_user(priv_user), .hit(if_hit),
      .perm(x_vec), .lock(lock_vec), .fault(if_fault)
    );

    npc_decide #(.N(NUM_REGIONS)) u_ls_decide (
      .req(ls_req), .priv_user(priv_user), .hit(ls_hit),
      .perm(ls_we ? w_vec : r_vec), .lock(lock_vec), .fault(ls_deny)
    );

    assign ld_fault = ls_deny & ~ls_we;
    assign st_fault = ls_deny &  ls_we;

    AST_LS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_ni)
      $onehot0({ld_fault, st_fault})); // R11
    AST_IF_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
      !if_req |-> !if_fault); // R11
    AST_LS_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
      !ls_req |-> !(ld_fault || st_fault)); // R11
    AST_MACHINE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_ni)
      (!priv_user && (lock_vec == '0)) |-> !(if_fault || ld_fault || st_fault)); // R8
    AST_NO_HIT_ALLOWED: assert property (@(posedge clk) disable iff (!rst_ni)
      ((if_hit == '0) |-> !if_fault) and ((ls_hit == '0) |-> !(ld_fault || st_fault))); // R10
  end

endmodule

// File: tb/napot_guard_test.sv
module napot_guard_test;

  localparam int N  = 4;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          csr_we, csr_is_addr;
  logic [1:0]    csr_idx;
  logic [31:0]   csr_wdata;
  logic          priv_user, if_req, ls_req, ls_we;
  logic [AW-1:0] if_addr, ls_addr;
  logic          if_fault, ld_fault, st_fault;

  always #4 clk = ~clk;

  napot_guard #(.NUM_REGIONS(N), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_is_addr(csr_is_addr),
    .csr_idx(csr_idx), .csr_wdata(csr_wdata), .priv_user(priv_user),
    .if_req(if_req), .if_addr(if_addr), .if_fault(if_fault),
    .ls_req(ls_req), .ls_we(ls_we), .ls_addr(ls_addr),
    .ld_fault(ld_fault), .st_fault(st_fault)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  // monitor: compare {if,ld,st} two ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({if_fault, ld_fault, st_fault} !== e) begin
          fails++;
          $display("FAIL %s: got %b expected %b", t,
                   {if_fault, ld_fault, st_fault}, e);
        end
      end
    end
  end

  task automatic csr_write(input bit is_addr, input int idx, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_is_addr = is_addr; csr_idx = idx[1:0]; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  // driver: apply one access pattern and queue its expected faults
  task automatic probe(input bit user, input bit ireq, input logic [AW-1:0] ia,
                       input bit lreq, input bit we, input logic [AW-1:0] la,
                       input logic [2:0] e, input string t);
    @(negedge clk);
    priv_user = user; if_req = ireq; if_addr = ia;
    ls_req = lreq; ls_we = we; ls_addr = la;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; csr_we = 1'b0; csr_is_addr = 1'b0; csr_idx = '0; csr_wdata = '0;
    priv_user = 1'b1; if_req = 1'b0; ls_req = 1'b0; ls_we = 1'b0;
    if_addr = '0; ls_addr = '0;
    settle(3);
    rst_n = 1'b1;
    settle(4);

    probe(1, 1, 32'h1010, 1, 1, 32'h1010, 3'b000, "R1 reset regions off");

    csr_write(1, 0, 32'h0000_041F);  // 256 B at 0x1000
    csr_write(0, 0, 32'h19);         // read only
    csr_write(1, 1, 32'h0000_05FF);  // 4 KiB at 0x1000
    csr_write(0, 1, 32'h1F);         // rwx
    csr_write(1, 2, 32'h0000_2000);  // 8 B at 0x8000
    csr_write(0, 2, 32'h9C);         // exec only, locked
    csr_write(1, 3, 32'h0000_8001);  // 16 B at 0x20000
    csr_write(0, 3, 32'h08);         // mode 1 -> off
    settle(40);

    probe(1, 1, 32'h1010, 1, 1, 32'h1010, 3'b101, "R9 R6 R7 lowest region decides");
    probe(1, 1, 32'h1800, 1, 0, 32'h1010, 3'b000, "R5 load with read bit");
    probe(1, 1, 32'h1800, 1, 1, 32'h1800, 3'b000, "R9 second region rwx");
    probe(1, 0, 32'h0,    1, 1, 32'h10FF, 3'b001, "R3 last byte of 256 B region");
    probe(1, 0, 32'h0,    1, 1, 32'h1100, 3'b000, "R3 first byte past 256 B region");
    probe(1, 1, 32'h0FFC, 1, 1, 32'h0FFC, 3'b000, "R10 unmatched allowed");
    probe(1, 0, 32'h0,    1, 0, 32'h8004, 3'b010, "R5 user load exec-only");
    probe(1, 1, 32'h8000, 1, 0, 32'h8007, 3'b010, "R7 fetch allowed by exec bit");
    probe(1, 0, 32'h0,    1, 0, 32'h8008, 3'b000, "R3 8 B region boundary");
    probe(0, 0, 32'h0,    1, 0, 32'h8004, 3'b010, "R8 machine checked when locked");
    probe(0, 1, 32'h1010, 1, 1, 32'h1010, 3'b000, "R8 machine skips unlocked");
    probe(1, 0, 32'h0,    1, 0, 32'h20000, 3'b000, "R2 mode 1 acts as off");
    probe(1, 0, 32'h1010, 0, 1, 32'h1010, 3'b000, "R11 no request no fault");

    csr_write(0, 3, 32'h18);         // pow2 mode, no permissions
    probe(1, 0, 32'h0,    1, 0, 32'h20000, 3'b010, "R2 mode 3 enables region");
    probe(1, 0, 32'h0,    1, 0, 32'h2000F, 3'b010, "R3 16 B region top");
    probe(1, 0, 32'h0,    1, 0, 32'h20010, 3'b000, "R3 16 B region end");
    probe(1, 1, 32'h2000C, 0, 0, 32'h0,    3'b100, "R7 fetch without exec");

    csr_write(1, 3, 32'h0000_8007);  // 64 B at 0x20000
    probe(1, 0, 32'h0,    1, 0, 32'h20000, 3'b000, "R4 not ready during walk");
    settle(40);
    probe(1, 0, 32'h0,    1, 0, 32'h20030, 3'b010, "R4 ready after walk");
    probe(1, 0, 32'h0,    1, 0, 32'h2003F, 3'b010, "R3 64 B region top");
    probe(1, 0, 32'h0,    1, 0, 32'h20040, 3'b000, "R3 64 B region end");

    csr_write(0, 3, 32'h10);         // mode 2 -> off
    probe(1, 0, 32'h0,    1, 0, 32'h20000, 3'b000, "R2 mode 2 acts as off");

    settle(4);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule